// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block carries out the hardware part of taking an interrupt. When a request arrives with a vector number and the global interrupt enable is set, the sequencer takes the bus as a master. It reads the handler address from a vector table and saves the program counter and the condition-code byte on a stack that grows downward. It then hands back the new program counter and the new stack pointer, and asks for the global enable to be cleared. The surrounding core supplies its current PC, CCR and SP. It loads the two results when the done pulse comes, and it clears its enable flag on the clear pulse.

Every memory transfer moves one byte over a byte-addressed port. A transfer is held until the memory answers with ready. One entry takes two reads and four writes, in a fixed order. Words are stored big-endian: the high byte goes to the lower address. The condition-code byte is written to both bytes of its stack word.

Top module: `irq_entry_seq`

## Requirements
- R1: During reset and in the cycle after any reset cycle, mem_req, done and gie_clr are all 0.
- R2: A request is taken only when the sequencer is idle and both irq_req and gie are 1 at a clock edge. gie_clr is then 1 for exactly the next cycle. With gie at 0 there is no bus activity and no gie_clr.
- R3: The first two transfers are reads (mem_we=0) at the table address A = 2*vector and at A+1. The byte read at A is the high byte of the handler address and the byte read at A+1 is the low byte.
- R4: The third and fourth transfers are writes (mem_we=1): PC[15:8] at SP-2, then PC[7:0] at SP-1.
- R5: The fifth and sixth transfers are writes of the CCR byte, at SP-4 and then at SP-3.
- R6: The PC, CCR, SP and vector used for the whole entry are the values on the inputs at the accepting edge. Changes to those inputs later in the entry have no effect.
- R7: A transfer completes only at an edge where mem_req and mem_rdy are both 1. While it waits, mem_addr, mem_we and mem_wdata stay unchanged.
- R8: After the sixth transfer, done is 1 for exactly one cycle. In that cycle new_pc equals the handler address and new_sp equals SP-4.
- R9: A request present while an entry is in progress is ignored, including in the done cycle. A request still held after done is taken at the first idle edge.
- R10: All stack addresses and new_sp wrap modulo 2^16. For example, SP=0x0001 gives writes at 0xFFFF, 0x0000, 0xFFFD and 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Interrupt request level |
| irq_vec | input | 7 | Vector number of the request |
| gie | input | 1 | Global interrupt enable of the core |
| cur_pc | input | 16 | Current program counter |
| cur_ccr | input | 8 | Current condition-code byte |
| cur_sp | input | 16 | Current stack pointer |
| mem_req | output | 1 | Bus transfer request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Byte address of the transfer |
| mem_wdata | output | 8 | Write data byte |
| mem_rdata | input | 8 | Read data byte, valid with mem_rdy |
| mem_rdy | input | 1 | Transfer completes at an edge where this and mem_req are 1 |
| new_pc | output | 16 | Handler address, valid while done is 1 |
| new_sp | output | 16 | Stack pointer after the pushes, valid while done is 1 |
| gie_clr | output | 1 | One-cycle request to clear the global enable |
| done | output | 1 | One-cycle completion pulse |

## Verification
The done cycle of one entry can coincide with a fresh request, since a core may raise its next interrupt while the previous entry finishes. The bench holds irq_req and gie high from the start of an entry through its done cycle. It expects no gie_clr and no bus request in the idle cycle that follows done. It expects both in the cycle after that, and then a complete second entry. A transfer that waits on mem_rdy can also overlap the input changes made after acceptance. The bench scrambles PC, CCR, SP and the vector right after acceptance, under three ready patterns. Every byte on the bus is judged against values computed from the inputs captured at acceptance.

// File: rtl/irq_entry_pkg.sv
// Package: shared types of the interrupt entry sequencer.
// Assumes nothing; holds only the state encoding used by control and bus logic.
package irq_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_VEC_RD   = 3'd1,
        ST_PUSH_PC  = 3'd2,
        ST_PUSH_CCR = 3'd3,
        ST_LOAD_PC  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/irq_entry_ctrl.sv
// Module: irq_entry_ctrl
// Walks the entry sequence: idle, two table reads, two PC writes,
// two CCR writes, one completion cycle. Each bus state holds two byte
// beats selected by 'lane'; a beat ends only on an edge with mem_rdy.
// Assumes mem_rdy is sampled only while a bus state is active.
module irq_entry_ctrl
    import irq_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_req,
    input  logic       gie,
    input  logic       mem_rdy,
    output seq_state_e state,
    output logic       lane,
    output logic       accept,
    output logic       xfer,
    output logic       gie_clr,
    output logic       done
);

    seq_state_e state_nxt;
    logic       bus_state;
    logic       last_beat;

    // Purpose: decide whether a request is taken this cycle.
    always_comb begin
        accept = (state == ST_IDLE) && irq_req && gie;
    end

    // Purpose: flag the states that own the bus and a finished beat.
    always_comb begin
        bus_state = (state == ST_VEC_RD) || (state == ST_PUSH_PC) ||
                    (state == ST_PUSH_CCR);
        xfer      = bus_state && mem_rdy;
        last_beat = xfer && lane;
    end

    // Purpose: next-state selection in the fixed entry order.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_IDLE:     if (accept)    state_nxt = ST_VEC_RD;
            ST_VEC_RD:   if (last_beat) state_nxt = ST_PUSH_PC;
            ST_PUSH_PC:  if (last_beat) state_nxt = ST_PUSH_CCR;
            ST_PUSH_CCR: if (last_beat) state_nxt = ST_LOAD_PC;
            ST_LOAD_PC:                 state_nxt = ST_IDLE;
            default:                    state_nxt = ST_IDLE;
        endcase
    end

    // Purpose: state, beat lane and enable-clear pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lane    <= 1'b0;
            gie_clr <= 1'b0;
        end else begin
            state   <= state_nxt;
            gie_clr <= accept;
            if (xfer) begin
                lane <= ~lane;
            end else if (state == ST_IDLE) begin
                lane <= 1'b0;
            end
        end
    end

    // Purpose: completion pulse lasts exactly the single load cycle.
    always_comb begin
        done = (state == ST_LOAD_PC);
    end

endmodule

// File: rtl/irq_entry_ctx.sv
// Module: irq_entry_ctx
// Holds the context frozen at acceptance (vector, PC, CCR, SP) and
// assembles the handler address from the two table bytes.
// Assumes the strobes are one-cycle and mutually exclusive.
module irq_entry_ctx #(
    parameter int BYTE_W = 8,
    parameter int VEC_W  = 7,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              take_hi,
    input  logic              take_lo,
    input  logic [VEC_W-1:0]  in_vec,
    input  logic [WORD_W-1:0] in_pc,
    input  logic [BYTE_W-1:0] in_ccr,
    input  logic [WORD_W-1:0] in_sp,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [VEC_W-1:0]  cap_vec,
    output logic [WORD_W-1:0] cap_pc,
    output logic [BYTE_W-1:0] cap_ccr,
    output logic [WORD_W-1:0] cap_sp,
    output logic [WORD_W-1:0] handler
);

    logic [BYTE_W-1:0] hdl_hi;
    logic [BYTE_W-1:0] hdl_lo;

    // Purpose: freeze the core context on the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vec <= '0;
            cap_pc  <= '0;
            cap_ccr <= '0;
            cap_sp  <= '0;
        end else if (accept) begin
            cap_vec <= in_vec;
            cap_pc  <= in_pc;
            cap_ccr <= in_ccr;
            cap_sp  <= in_sp;
        end
    end

    // Purpose: collect the big-endian handler address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdl_hi <= '0;
            hdl_lo <= '0;
        end else begin
            if (take_hi) hdl_hi <= rd_byte;
            if (take_lo) hdl_lo <= rd_byte;
        end
    end

    // Purpose: present the assembled handler address.
    always_comb begin
        handler = {hdl_hi, hdl_lo};
    end

endmodule

// File: rtl/irq_entry_busgen.sv
// Module: irq_entry_busgen
// Drives the byte bus from state and lane: table reads at 2*vector and
// 2*vector+1, then the PC and CCR stack writes, high byte at the lower
// address. Purely combinational; the held state keeps outputs stable.
// Assumes VEC_W + 1 <= 2*BYTE_W.
module irq_entry_busgen
    import irq_entry_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int VEC_W  = 7,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  seq_state_e        state,
    input  logic              lane,
    input  logic [VEC_W-1:0]  cap_vec,
    input  logic [WORD_W-1:0] cap_pc,
    input  logic [BYTE_W-1:0] cap_ccr,
    input  logic [WORD_W-1:0] cap_sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [WORD_W-1:0] sp_final
);

    logic [WORD_W-1:0] tbl_addr;
    logic [WORD_W-1:0] sp_m1;
    logic [WORD_W-1:0] sp_m2;
    logic [WORD_W-1:0] sp_m3;
    logic [WORD_W-1:0] sp_m4;

    // Purpose: form the table address, padding only when the vector is narrow.
    generate
        if (VEC_W + 1 == WORD_W) begin : g_tbl_full
            always_comb tbl_addr = {cap_vec, 1'b0};
        end else begin : g_tbl_pad
            always_comb tbl_addr = {{(WORD_W - VEC_W - 1){1'b0}}, cap_vec, 1'b0};
        end
    endgenerate

    // Purpose: stack slot addresses, wrapping modulo the address space.
    always_comb begin
        sp_m1    = cap_sp - WORD_W'(1);
        sp_m2    = cap_sp - WORD_W'(2);
        sp_m3    = cap_sp - WORD_W'(3);
        sp_m4    = cap_sp - WORD_W'(4);
        sp_final = sp_m4;
    end

    // Purpose: select the transfer of the current beat.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_VEC_RD: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr + WORD_W'(lane);
            end
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lane ? sp_m1 : sp_m2;
                mem_wdata = lane ? cap_pc[BYTE_W-1:0] : cap_pc[WORD_W-1:BYTE_W];
            end
            ST_PUSH_CCR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lane ? sp_m3 : sp_m4;
                mem_wdata = cap_ccr;
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/irq_entry_seq.sv
// Module: irq_entry_seq (top)
// Interrupt entry bus master: on an enabled request it reads the handler
// address from the vector table, pushes PC and a doubled CCR byte on a
// descending stack, and returns new PC and SP with a done pulse.
// Assumes the core clears its enable on gie_clr and loads PC/SP on done.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int VEC_W  = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  irq_req,
    input  logic [VEC_W-1:0]      irq_vec,
    input  logic                  gie,
    input  logic [2*BYTE_W-1:0]   cur_pc,
    input  logic [BYTE_W-1:0]     cur_ccr,
    input  logic [2*BYTE_W-1:0]   cur_sp,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [2*BYTE_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]     mem_wdata,
    input  logic [BYTE_W-1:0]     mem_rdata,
    input  logic                  mem_rdy,
    output logic [2*BYTE_W-1:0]   new_pc,
    output logic [2*BYTE_W-1:0]   new_sp,
    output logic                  gie_clr,
    output logic                  done
);

    localparam int WORD_W = 2 * BYTE_W;

    seq_state_e        state;
    logic              lane;
    logic              accept;
    logic              xfer;
    logic              busy;
    logic              take_hi;
    logic              take_lo;
    logic [VEC_W-1:0]  cap_vec;
    logic [WORD_W-1:0] cap_pc;
    logic [BYTE_W-1:0] cap_ccr;
    logic [WORD_W-1:0] cap_sp;
    logic [WORD_W-1:0] handler;

    irq_entry_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .gie     (gie),
        .mem_rdy (mem_rdy),
        .state   (state),
        .lane    (lane),
        .accept  (accept),
        .xfer    (xfer),
        .gie_clr (gie_clr),
        .done    (done)
    );

    // Purpose: table byte strobes and the busy flag seen by the checker.
    always_comb begin
        take_hi = xfer && (state == ST_VEC_RD) && !lane;
        take_lo = xfer && (state == ST_VEC_RD) && lane;
        busy    = (state != ST_IDLE);
    end

    irq_entry_ctx #(
        .BYTE_W (BYTE_W),
        .VEC_W  (VEC_W)
    ) u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .take_hi (take_hi),
        .take_lo (take_lo),
        .in_vec  (irq_vec),
        .in_pc   (cur_pc),
        .in_ccr  (cur_ccr),
        .in_sp   (cur_sp),
        .rd_byte (mem_rdata),
        .cap_vec (cap_vec),
        .cap_pc  (cap_pc),
        .cap_ccr (cap_ccr),
        .cap_sp  (cap_sp),
        .handler (handler)
    );

    irq_entry_busgen #(
        .BYTE_W (BYTE_W),
        .VEC_W  (VEC_W)
    ) u_bus (
        .state     (state),
        .lane      (lane),
        .cap_vec   (cap_vec),
        .cap_pc    (cap_pc),
        .cap_ccr   (cap_ccr),
        .cap_sp    (cap_sp),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sp_final  (new_sp)
    );

    // Purpose: the handler address becomes the new program counter.
    always_comb begin
        new_pc = handler;
    end

endmodule

// File: rtl/irq_entry_chk.sv
// Module: irq_entry_chk
// Temporal checks on the sequencer's ports and busy flag; bound to the top.
module irq_entry_chk #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              gie,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_rdy,
    input logic [WORD_W-1:0] mem_addr,
    input logic [BYTE_W-1:0] mem_wdata,
    input logic              gie_clr,
    input logic              done
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !done && !gie_clr)); // R1

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && irq_req && gie) |=> gie_clr); // R2

    AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |=> !gie_clr); // R2

    AST_FIRST_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |-> (mem_req && !mem_we)); // R3

    AST_HOLD_UNTIL_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata))); // R7

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_we && mem_rdy)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |-> !$past(busy)); // R9

endmodule

bind irq_entry_seq irq_entry_chk #(
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .gie       (gie),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_rdy   (mem_rdy),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .gie_clr   (gie_clr),
    .done      (done)
);

// File: tb/sim_irq_entry_seq.sv
// Bench: sweeps every vector number under three ready patterns, plus
// stack-pointer wrap cases, back-to-back requests and disabled requests.
module sim_irq_entry_seq;

    localparam int CLK_PERIOD = 10;
    localparam int BYTE_W     = 8;
    localparam int VEC_W      = 7;
    localparam int WORD_W     = 2 * BYTE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              irq_req = 1'b0;
    logic [VEC_W-1:0]  irq_vec = '0;
    logic              gie = 1'b0;
    logic [WORD_W-1:0] cur_pc = '0;
    logic [BYTE_W-1:0] cur_ccr = '0;
    logic [WORD_W-1:0] cur_sp = '0;
    logic              mem_req;
    logic              mem_we;
    logic [WORD_W-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_wdata;
    logic [BYTE_W-1:0] mem_rdata = '0;
    logic              mem_rdy = 1'b0;
    logic [WORD_W-1:0] new_pc;
    logic [WORD_W-1:0] new_sp;
    logic              gie_clr;
    logic              done;

    irq_entry_seq #(.BYTE_W(BYTE_W), .VEC_W(VEC_W)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int n_acc = 0;
    int n_gclr = 0;
    int n_done = 0;
    int hold_err = 0;
    int stall_mode = 0;
    bit finished = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [WORD_W-1:0] log_addr [0:15];
    logic              log_we   [0:15];
    logic [BYTE_W-1:0] log_wd   [0:15];
    logic [WORD_W-1:0] got_pc = '0;
    logic [WORD_W-1:0] got_sp = '0;
    logic              pend = 1'b0;
    logic [WORD_W-1:0] p_addr = '0;
    logic              p_we = 1'b0;
    logic [BYTE_W-1:0] p_wd = '0;

    function automatic logic [7:0] tbl_byte(input logic [15:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd29;
        return m ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Memory model and monitor, all at the falling edge.
    always @(negedge clk) begin
        logic rdy;
        if (pend) begin
            if (!(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wd))
                hold_err++;
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (stall_mode)
            0:       rdy = 1'b1;
            1:       rdy = lfsr[0] | lfsr[3];
            default: rdy = lfsr[0] & lfsr[5];
        endcase
        mem_rdy   = rdy;
        mem_rdata = tbl_byte(mem_addr);
        if (rst_n && mem_req && rdy && n_acc < 16) begin
            log_addr[n_acc] = mem_addr;
            log_we[n_acc]   = mem_we;
            log_wd[n_acc]   = mem_wdata;
            n_acc++;
        end
        pend   = rst_n && mem_req && !rdy;
        p_addr = mem_addr;
        p_we   = mem_we;
        p_wd   = mem_wdata;
        if (rst_n && gie_clr) n_gclr++;
        if (rst_n && done) begin
            n_done++;
            got_pc = new_pc;
            got_sp = new_sp;
        end
    end

    task automatic clear_logs();
        n_acc = 0; n_gclr = 0; n_done = 0; hold_err = 0;
    endtask

    task automatic wait_done(input int target);
        int t;
        t = 0;
        while (n_done < target && t < 3000) begin
            @(negedge clk); #1;
            t++;
        end
    endtask

    // One interrupt entry, checked byte by byte against the captured inputs.
    task automatic run_seq(input logic [VEC_W-1:0] vec, input logic [15:0] pc,
                           input logic [7:0] ccr, input logic [15:0] sp,
                           input bit keep);
        logic [15:0] va;
        logic [15:0] hdl;
        @(negedge clk); #1;
        clear_logs();
        irq_vec = vec; cur_pc = pc; cur_ccr = ccr; cur_sp = sp;
        gie = 1'b1; irq_req = 1'b1;
        while (n_gclr == 0) begin
            @(negedge clk); #1;
        end
        // R6: scramble the context once the request has been taken.
        cur_pc = ~pc; cur_ccr = ~ccr; cur_sp = sp ^ 16'h5555; irq_vec = ~vec;
        wait_done(1);
        if (!keep) irq_req = 1'b0;
        va  = {8'h00, vec, 1'b0};
        hdl = {tbl_byte(va), tbl_byte(va + 16'd1)};
        chk(n_acc == 6, "R9 transfer count", n_acc, 6);
        chk(log_addr[0] == va && !log_we[0], "R3 read hi addr", log_addr[0], va);
        chk(log_addr[1] == va + 16'd1 && !log_we[1], "R3 read lo addr", log_addr[1], va + 16'd1);
        chk(log_addr[2] == sp - 16'd2 && log_we[2], "R4 R10 PC hi addr", log_addr[2], sp - 16'd2);
        chk(log_wd[2] == pc[15:8], "R4 R6 PC hi data", log_wd[2], pc[15:8]);
        chk(log_addr[3] == sp - 16'd1 && log_we[3], "R4 R10 PC lo addr", log_addr[3], sp - 16'd1);
        chk(log_wd[3] == pc[7:0], "R4 R6 PC lo data", log_wd[3], pc[7:0]);
        chk(log_addr[4] == sp - 16'd4 && log_we[4], "R5 R10 CCR addr 0", log_addr[4], sp - 16'd4);
        chk(log_addr[5] == sp - 16'd3 && log_we[5], "R5 R10 CCR addr 1", log_addr[5], sp - 16'd3);
        chk(log_wd[4] == ccr && log_wd[5] == ccr, "R5 R6 CCR data",
            {log_wd[4], log_wd[5]}, {ccr, ccr});
        chk(got_pc == hdl, "R8 R3 new_pc", got_pc, hdl);
        chk(got_sp == sp - 16'd4, "R8 R10 new_sp", got_sp, sp - 16'd4);
        chk(n_gclr == 1, "R2 gie_clr pulses", n_gclr, 1);
        chk(hold_err == 0, "R7 hold while waiting", hold_err, 0);
        @(negedge clk); #1;
        if (keep) begin
            // R9: the request held through done is only taken once idle.
            chk(mem_req == 1'b0 && n_gclr == 1, "R9 ignored in done cycle",
                {mem_req, 8'(n_gclr)}, {1'b0, 8'd1});
            @(negedge clk); #1;
            chk(mem_req == 1'b1 && n_gclr == 2, "R9 taken at first idle edge",
                {mem_req, 8'(n_gclr)}, {1'b1, 8'd2});
            irq_req = 1'b0;
            wait_done(2);
            chk(n_done == 2 && n_acc == 12, "R9 second entry completes",
                {8'(n_done), 8'(n_acc)}, {8'd2, 8'd12});
            @(negedge clk); #1;
        end
        chk(n_done == (keep ? 2 : 1) && !done, "R8 done is one cycle", n_done, keep ? 2 : 1);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        irq_req = 1'b1; gie = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!mem_req && !done && !gie_clr, "R1 reset outputs",
            {mem_req, done, gie_clr}, 3'b000);
        irq_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R2: disabled requests cause nothing.
        clear_logs();
        gie = 1'b0; irq_req = 1'b1; irq_vec = 7'd9;
        repeat (8) begin
            @(negedge clk); #1;
            chk(!mem_req && !gie_clr, "R2 no entry while disabled",
                {mem_req, gie_clr}, 2'b00);
        end
        irq_req = 1'b0;
        chk(n_gclr == 0 && n_acc == 0, "R2 no clear while disabled", n_gclr, 0);

        // Full vector sweep under three ready patterns.
        for (int v = 0; v < (1 << VEC_W); v++) begin
            stall_mode = v % 3;
            run_seq(VEC_W'(v), 16'(v * 16'h0123 + 16'h4A00), 8'(v * 7 + 3),
                    16'(16'h8000 - v * 16'h22), (v % 16) == 5);
        end

        // R10: stack pointer wrap cases.
        for (int k = 0; k < 5; k++) begin
            logic [15:0] sps [0:4];
            sps[0] = 16'h0000; sps[1] = 16'h0001; sps[2] = 16'h0002;
            sps[3] = 16'h0003; sps[4] = 16'hFFFF;
            stall_mode = k % 3;
            run_seq(VEC_W'(127 - k), 16'hF00D ^ 16'(k), 8'hA5 + 8'(k), sps[k], 1'b0);
        end

        // R1: reset in the middle of an entry silences the bus.
        stall_mode = 2;
        @(negedge clk); #1;
        irq_vec = 7'd3; gie = 1'b1; irq_req = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        irq_req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk(!mem_req && !done && !gie_clr, "R1 reset mid entry",
            {mem_req, done, gie_clr}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!mem_req, "R1 idle after reset", mem_req, 1'b0);

        finish_run();
    end

endmodule